// File: doc/BRIEF.md
# Single-Bank DRAM Command Sequencer

This block sits between a simple word-access client and one DRAM bank. Each client request names a row, a column and, for writes, a data word. The sequencer turns it into the bank's command stream: activate a row, read or write a column, precharge, and refresh. It remembers which row the sense amplifiers hold, so it knows when an access can go straight to the column and when the bank must first be closed and reopened.

A static policy input chooses how the bank is left after an access. With the open-page policy the row stays latched, and the next access to the same row goes straight to its column command. With the closed-page policy every column command is followed by a precharge. That policy suits scattered traffic. An interval timer raises a refresh demand, and it wins over any waiting request. The bank is closed before the refresh command goes out. Minimum command spacings and the read return latency are parameters counted in clock cycles.

The client side has a ready/valid request port that holds one request at a time. Read results come back in request order, with a one-cycle valid strobe.

Top module: `dram_seq`

## Requirements
- R1: While reset is asserted and in the first cycle after release, `dram_cmd` is 0 (no operation), `rsp_valid` is low and `req_ready` is high.
- R2: `dram_cmd` encodes 0 = no operation, 1 = activate (row on `dram_row`), 2 = column read and 3 = column write (column on `dram_col`, write word on `dram_wdata`), 4 = precharge, 5 = refresh. A read returns the word most recently written to the same row and column.
- R3: An activate is only issued while no row is open. An access to a row other than the open one is preceded by a precharge.
- R4: Command spacing: a column command comes at least T_RCD cycles after its activate. An activate or refresh comes at least T_RP cycles after a precharge. No command comes within T_RFC cycles after a refresh.
- R5: With `closed_page` low, an access to the open row issues no activate.
- R6: With `closed_page` high, the command after every column command is a precharge, one cycle later, so every access issues its own activate.
- R7: A refresh is issued only with the bank closed, one per T_REFI cycles on average. No row is open after it.
- R8: A refresh that falls due wins over a waiting request. Under continuous traffic, no gap between refreshes exceeds T_REFI+16 cycles.
- R9: For a column read visible on `dram_cmd` in cycle k, `rsp_valid` is high in cycle k+RD_LAT+1. `rsp_rdata` then carries the value that was on `dram_rdata` in cycle k+RD_LAT. Responses keep request order.
- R10: A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is then low in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| closed_page | input | 1 | Policy select, static: 1 closes the bank after each access |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request slot empty |
| req_we | input | 1 | 1 = write, 0 = read |
| req_row | input | ROW_W | Row address |
| req_col | input | COL_W | Column address |
| req_wdata | input | DATA_W | Write word |
| rsp_valid | output | 1 | Read result strobe |
| rsp_rdata | output | DATA_W | Read result word |
| dram_cmd | output | 3 | Command code |
| dram_row | output | ROW_W | Row address for activate |
| dram_col | output | COL_W | Column address for read or write |
| dram_wdata | output | DATA_W | Data for column write |
| dram_rdata | input | DATA_W | Data returned by the bank |

## Verification
Runs of writes followed by reads within one row, under the open-page policy, show whether row hits skip activation. Accesses that alternate between two rows force a precharge and a fresh activate on every access, which tests row-miss handling and spacing. The same-row reads repeated under the closed-page policy must each activate anew, which separates the two policies. A long mixed stream of reads and writes over four rows, followed by an idle stretch, shows that refresh keeps its rate both under load and with no traffic. A behavioural bank model in the bench rejects any command order or spacing that is illegal.

// File: rtl/dram_seq_pkg.sv
package dram_seq_pkg;

    typedef enum logic [2:0] {
        CMD_NOP = 3'd0,
        CMD_ACT = 3'd1,
        CMD_RD  = 3'd2,
        CMD_WR  = 3'd3,
        CMD_PRE = 3'd4,
        CMD_REF = 3'd5
    } dram_cmd_e;

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/dram_gap_timer.sv
module dram_gap_timer #(
    parameter int GAP_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [GAP_W-1:0] load_val,
    output logic             idle
);

    typedef struct packed {
        logic [GAP_W-1:0] cnt;
    } gap_t;

    gap_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.cnt = load_val;
        end else if (st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign idle = (st_q.cnt == '0);

    // R4
    gap_respected_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cnt != '0) |-> !load);

endmodule

// File: rtl/dram_refresh_timer.sv
module dram_refresh_timer #(
    parameter int T_REFI = 120
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ack,
    output logic pending
);

    localparam int CW = $clog2(T_REFI + 1);
    localparam logic [CW-1:0] LAST = CW'(T_REFI - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          pend;
    } ref_t;

    ref_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (ack) st_d.pend = 1'b0;
        if (st_q.cnt == LAST) begin
            st_d.cnt  = '0;
            st_d.pend = 1'b1;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pending = st_q.pend;

    // R7
    ack_when_due_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> st_q.pend);

endmodule

// File: rtl/dram_rd_return.sv
module dram_rd_return #(
    parameter int DATA_W = 16,
    parameter int RD_LAT = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_issue,
    input  logic [DATA_W-1:0] dram_rdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata
);

    typedef struct packed {
        logic [RD_LAT-1:0] pipe;
        logic              v;
        logic [DATA_W-1:0] data;
    } ret_t;

    ret_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.pipe[0] = rd_issue;
        for (int i = 1; i < RD_LAT; i++) begin
            st_d.pipe[i] = st_q.pipe[i-1];
        end
        st_d.v = st_q.pipe[RD_LAT-1];
        if (st_q.pipe[RD_LAT-1]) st_d.data = dram_rdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rsp_valid = st_q.v;
    assign rsp_rdata = st_q.data;

endmodule

// File: rtl/dram_seq.sv
module dram_seq
    import dram_seq_pkg::*;
#(
    parameter int ROW_W  = 8,
    parameter int COL_W  = 6,
    parameter int DATA_W = 16,
    parameter int T_RCD  = 3,
    parameter int T_RP   = 2,
    parameter int T_RFC  = 6,
    parameter int T_REFI = 120,
    parameter int RD_LAT = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              closed_page,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_we,
    input  logic [ROW_W-1:0]  req_row,
    input  logic [COL_W-1:0]  req_col,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [2:0]        dram_cmd,
    output logic [ROW_W-1:0]  dram_row,
    output logic [COL_W-1:0]  dram_col,
    output logic [DATA_W-1:0] dram_wdata,
    input  logic [DATA_W-1:0] dram_rdata
);

    localparam int GAP_MAX = max3(T_RCD, T_RP, T_RFC);
    localparam int GAP_W   = $clog2(GAP_MAX + 1);
    localparam logic [GAP_W-1:0] LD_RCD = GAP_W'(T_RCD - 1);
    localparam logic [GAP_W-1:0] LD_RP  = GAP_W'(T_RP - 1);
    localparam logic [GAP_W-1:0] LD_RFC = GAP_W'(T_RFC - 1);
    localparam logic [GAP_W-1:0] LD_COL = '0;

    typedef struct packed {
        logic              open;
        logic [ROW_W-1:0]  open_row;
        logic              used;
        logic              slot_v;
        logic              slot_we;
        logic [ROW_W-1:0]  slot_row;
        logic [COL_W-1:0]  slot_col;
        logic [DATA_W-1:0] slot_data;
        dram_cmd_e         cmd;
        logic [ROW_W-1:0]  cmd_row;
        logic [COL_W-1:0]  cmd_col;
        logic [DATA_W-1:0] cmd_wdata;
    } seq_t;

    seq_t st_d, st_q;

    logic             gap_idle;
    logic             gap_load;
    logic [GAP_W-1:0] gap_val;
    logic             ref_pend;
    logic             ref_ack;
    logic             row_hit;

    assign row_hit   = st_q.open && (st_q.open_row == st_q.slot_row);
    assign req_ready = !st_q.slot_v;

    always_comb begin
        st_d     = st_q;
        st_d.cmd = CMD_NOP;
        gap_load = 1'b0;
        gap_val  = '0;
        ref_ack  = 1'b0;

        if (!st_q.slot_v && req_valid) begin
            st_d.slot_v    = 1'b1;
            st_d.slot_we   = req_we;
            st_d.slot_row  = req_row;
            st_d.slot_col  = req_col;
            st_d.slot_data = req_wdata;
        end

        if (gap_idle) begin
            if (ref_pend) begin
                if (st_q.open) begin
                    st_d.cmd  = CMD_PRE;
                    st_d.open = 1'b0;
                    st_d.used = 1'b0;
                    gap_load  = 1'b1;
                    gap_val   = LD_RP;
                end else begin
                    st_d.cmd = CMD_REF;
                    ref_ack  = 1'b1;
                    gap_load = 1'b1;
                    gap_val  = LD_RFC;
                end
            end else if (closed_page && st_q.open && st_q.used) begin
                st_d.cmd  = CMD_PRE;
                st_d.open = 1'b0;
                st_d.used = 1'b0;
                gap_load  = 1'b1;
                gap_val   = LD_RP;
            end else if (st_q.slot_v) begin
                if (row_hit) begin
                    st_d.cmd       = st_q.slot_we ? CMD_WR : CMD_RD;
                    st_d.cmd_row   = st_q.open_row;
                    st_d.cmd_col   = st_q.slot_col;
                    st_d.cmd_wdata = st_q.slot_data;
                    st_d.slot_v    = 1'b0;
                    st_d.used      = 1'b1;
                    gap_load       = 1'b1;
                    gap_val        = LD_COL;
                end else if (st_q.open) begin
                    st_d.cmd  = CMD_PRE;
                    st_d.open = 1'b0;
                    st_d.used = 1'b0;
                    gap_load  = 1'b1;
                    gap_val   = LD_RP;
                end else begin
                    st_d.cmd      = CMD_ACT;
                    st_d.cmd_row  = st_q.slot_row;
                    st_d.open     = 1'b1;
                    st_d.open_row = st_q.slot_row;
                    st_d.used     = 1'b0;
                    gap_load      = 1'b1;
                    gap_val       = LD_RCD;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    dram_gap_timer #(
        .GAP_W (GAP_W)
    ) u_gap (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (gap_load),
        .load_val (gap_val),
        .idle     (gap_idle)
    );

    dram_refresh_timer #(
        .T_REFI (T_REFI)
    ) u_refresh (
        .clk     (clk),
        .rst_n   (rst_n),
        .ack     (ref_ack),
        .pending (ref_pend)
    );

    dram_rd_return #(
        .DATA_W (DATA_W),
        .RD_LAT (RD_LAT)
    ) u_rd_return (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_issue   (st_q.cmd == CMD_RD),
        .dram_rdata (dram_rdata),
        .rsp_valid  (rsp_valid),
        .rsp_rdata  (rsp_rdata)
    );

    assign dram_cmd   = st_q.cmd;
    assign dram_row   = st_q.cmd_row;
    assign dram_col   = st_q.cmd_col;
    assign dram_wdata = st_q.cmd_wdata;

    // Observer of the bank state, rebuilt from the command stream alone
    logic obs_open_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            obs_open_q <= 1'b0;
        end else if (st_q.cmd == CMD_ACT) begin
            obs_open_q <= 1'b1;
        end else if (st_q.cmd == CMD_PRE) begin
            obs_open_q <= 1'b0;
        end
    end

    // R3
    act_on_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cmd == CMD_ACT) |-> !obs_open_q);

    // R7
    ref_on_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cmd == CMD_REF) |-> !obs_open_q);

    // R6
    closed_pre_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (closed_page && (st_q.cmd == CMD_RD || st_q.cmd == CMD_WR)) |=> (st_q.cmd == CMD_PRE));

    // R10
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

endmodule

// File: tb/dram_seq_tb.sv
`timescale 1ns/1ps
module dram_seq_tb;
    import dram_seq_pkg::*;

    localparam int ROW_W  = 8;
    localparam int COL_W  = 6;
    localparam int DATA_W = 16;
    localparam int T_RCD  = 3;
    localparam int T_RP   = 2;
    localparam int T_RFC  = 6;
    localparam int T_REFI = 120;
    localparam int RD_LAT = 4;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              closed_page;
    logic              req_valid;
    logic              req_ready;
    logic              req_we;
    logic [ROW_W-1:0]  req_row;
    logic [COL_W-1:0]  req_col;
    logic [DATA_W-1:0] req_wdata;
    logic              rsp_valid;
    logic [DATA_W-1:0] rsp_rdata;
    logic [2:0]        dram_cmd;
    logic [ROW_W-1:0]  dram_row;
    logic [COL_W-1:0]  dram_col;
    logic [DATA_W-1:0] dram_wdata;
    logic [DATA_W-1:0] dram_rdata = '0;

    always #4 clk = ~clk;

    dram_seq #(
        .ROW_W (ROW_W), .COL_W (COL_W), .DATA_W (DATA_W),
        .T_RCD (T_RCD), .T_RP (T_RP), .T_RFC (T_RFC),
        .T_REFI (T_REFI), .RD_LAT (RD_LAT)
    ) u_dut (
        .clk (clk), .rst_n (rst_n), .closed_page (closed_page),
        .req_valid (req_valid), .req_ready (req_ready), .req_we (req_we),
        .req_row (req_row), .req_col (req_col), .req_wdata (req_wdata),
        .rsp_valid (rsp_valid), .rsp_rdata (rsp_rdata),
        .dram_cmd (dram_cmd), .dram_row (dram_row), .dram_col (dram_col),
        .dram_wdata (dram_wdata), .dram_rdata (dram_rdata)
    );

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int addr_key(input logic [ROW_W-1:0] r, input logic [COL_W-1:0] c);
        return int'({r, c});
    endfunction

    // Behavioural bank model
    bit                m_open = 1'b0;
    logic [ROW_W-1:0]  m_row = '0;
    int                last_act = -1000, last_pre = -1000, last_ref = -1000;
    logic [DATA_W-1:0] mem_m [int];
    int                n_act = 0, n_pre = 0, n_ref = 0;
    bit                exp_pre = 1'b0;
    bit                track_gap = 1'b0;
    int                ref_prev = -1;
    int                ref_max_gap = 0;
    bit                hist_v [RD_LAT+1];
    logic [DATA_W-1:0] hist_d [RD_LAT+1];
    int                rd_cyc_q [$];

    // Scoreboard
    logic [DATA_W-1:0] shadow [int];
    logic [DATA_W-1:0] exp_q [$];

    initial begin
        for (int i = 0; i <= RD_LAT; i++) begin
            hist_v[i] = 1'b0;
            hist_d[i] = '0;
        end
    end

    always @(negedge clk) begin
        bit                rdh;
        logic [DATA_W-1:0] rdv;
        int                k;
        rdh = 1'b0;
        rdv = '0;
        if (rst_n) begin
            if (dram_cmd != 3'd0) begin
                chk(cyc - last_ref >= T_RFC, "R4", "cycles since refresh", cyc - last_ref, T_RFC);
                if (exp_pre) begin
                    chk(dram_cmd == 3'd4, "R6", "command after closed-page column", dram_cmd, 4);
                    exp_pre = 1'b0;
                end
            end
            case (dram_cmd_e'(dram_cmd))
                CMD_ACT: begin
                    chk(!m_open, "R3", "activate with row open", m_open, 0);
                    chk(cyc - last_pre >= T_RP, "R4", "precharge to activate", cyc - last_pre, T_RP);
                    m_open = 1'b1;
                    m_row = dram_row;
                    last_act = cyc;
                    n_act++;
                end
                CMD_RD, CMD_WR: begin
                    chk(m_open, "R3", "column with bank closed", m_open, 1);
                    chk(cyc - last_act >= T_RCD, "R4", "activate to column", cyc - last_act, T_RCD);
                    k = addr_key(m_row, dram_col);
                    if (dram_cmd == 3'd3) begin
                        mem_m[k] = dram_wdata;
                    end else begin
                        rdh = 1'b1;
                        rdv = mem_m.exists(k) ? mem_m[k] : '0;
                        rd_cyc_q.push_back(cyc);
                    end
                    if (closed_page) exp_pre = 1'b1;
                end
                CMD_PRE: begin
                    m_open = 1'b0;
                    last_pre = cyc;
                    n_pre++;
                end
                CMD_REF: begin
                    chk(!m_open, "R7", "refresh with row open", m_open, 0);
                    chk(cyc - last_pre >= T_RP, "R4", "precharge to refresh", cyc - last_pre, T_RP);
                    last_ref = cyc;
                    n_ref++;
                    if (track_gap && ref_prev >= 0 && cyc - ref_prev > ref_max_gap)
                        ref_max_gap = cyc - ref_prev;
                    ref_prev = cyc;
                end
                default: ;
            endcase
        end
        for (int i = RD_LAT; i > 0; i--) begin
            hist_v[i] = hist_v[i-1];
            hist_d[i] = hist_d[i-1];
        end
        hist_v[0] = rdh;
        hist_d[0] = rdv;
        dram_rdata <= hist_v[RD_LAT] ? hist_d[RD_LAT] : '0;
    end

    // Monitor: pops expected read words and issue cycles
    always @(negedge clk) begin
        logic [DATA_W-1:0] e;
        int                c;
        if (rst_n && rsp_valid) begin
            if (exp_q.size() == 0 || rd_cyc_q.size() == 0) begin
                chk(1'b0, "R9", "unexpected read response", 1, 0);
            end else begin
                e = exp_q.pop_front();
                c = rd_cyc_q.pop_front();
                chk(rsp_rdata == e, "R2", "read word", rsp_rdata, e);
                chk(cyc == c + RD_LAT + 1, "R9", "response cycle", cyc, c + RD_LAT + 1);
            end
        end
    end

    task automatic send(input bit we, input logic [ROW_W-1:0] row,
                        input logic [COL_W-1:0] col, input logic [DATA_W-1:0] d);
        int k;
        k = addr_key(row, col);
        @(negedge clk);
        req_valid = 1'b1;
        req_we    = we;
        req_row   = row;
        req_col   = col;
        req_wdata = d;
        while (!req_ready) @(negedge clk);
        @(posedge clk);
        if (we) shadow[k] = d;
        else    exp_q.push_back(shadow.exists(k) ? shadow[k] : '0);
        @(negedge clk);
        req_valid = 1'b0;
        chk(!req_ready, "R10", "ready after handshake", req_ready, 0);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        wait (cyc >= 150000);
        errors++;
        $display("FAIL watchdog: run did not complete actual=%0d expected=%0d", cyc, 150000);
        summary();
        $finish;
    end

    initial begin
        int a0, p0, r0;
        rst_n = 1'b0;
        closed_page = 1'b0;
        req_valid = 1'b0;
        req_we = 1'b0;
        req_row = '0;
        req_col = '0;
        req_wdata = '0;
        idle(3);
        // R1 during reset
        chk(dram_cmd == 3'd0, "R1", "command in reset", dram_cmd, 0);
        chk(!rsp_valid, "R1", "response valid in reset", rsp_valid, 0);
        chk(req_ready, "R1", "ready in reset", req_ready, 1);
        rst_n = 1'b1;
        @(negedge clk);
        chk(dram_cmd == 3'd0, "R1", "command after reset", dram_cmd, 0);
        chk(!rsp_valid, "R1", "response valid after reset", rsp_valid, 0);

        // Open page: fill one row, then read it back as hits (R5)
        for (int c = 0; c < 8; c++) send(1'b1, 8'd5, 6'(c), 16'h5000 + 16'(c));
        a0 = n_act;
        r0 = n_ref;
        for (int c = 0; c < 8; c++) send(1'b0, 8'd5, 6'(c), '0);
        idle(20);
        chk(n_act - a0 <= n_ref - r0, "R5", "activates on row hits", n_act - a0, n_ref - r0);
        chk(exp_q.size() == 0, "R9", "outstanding reads after hits", exp_q.size(), 0);

        // Open page: alternating rows force precharge each time (R3)
        p0 = n_pre;
        for (int i = 0; i < 6; i++) send(1'b1, (i % 2) ? 8'd9 : 8'd3, 6'(i), 16'hA000 + 16'(i));
        for (int i = 0; i < 6; i++) send(1'b0, (i % 2) ? 8'd9 : 8'd3, 6'(i), '0);
        idle(20);
        chk(n_pre - p0 >= 11, "R3", "precharges on row misses", n_pre - p0, 11);

        // Closed page: every access activates anew (R6)
        closed_page = 1'b1;
        idle(10);
        chk(!m_open, "R6", "bank closed under closed policy", m_open, 0);
        a0 = n_act;
        for (int c = 0; c < 6; c++) send(1'b0, 8'd5, 6'(c), '0);
        idle(30);
        chk(n_act - a0 == 6, "R6", "activates for six same-row reads", n_act - a0, 6);
        chk(!m_open, "R6", "bank closed after accesses", m_open, 0);

        // Heavy mixed traffic: refresh keeps priority (R8)
        closed_page = 1'b0;
        idle(10);
        ref_prev = -1;
        track_gap = 1'b1;
        for (int i = 0; i < 200; i++)
            send((i % 3) == 0, 8'(i % 4), 6'((i * 5) % 8), 16'(i * 16'h0101));
        idle(30);
        track_gap = 1'b0;
        chk(ref_max_gap > 0 && ref_max_gap <= T_REFI + 16, "R8", "largest refresh gap under load",
            ref_max_gap, T_REFI + 16);
        chk(exp_q.size() == 0, "R9", "outstanding reads after traffic", exp_q.size(), 0);

        // Idle: refresh rate (R7)
        r0 = n_ref;
        idle(10 * T_REFI);
        chk(n_ref - r0 >= 9 && n_ref - r0 <= 11, "R7", "refreshes in ten intervals", n_ref - r0, 10);
        chk(!m_open, "R7", "no row open after refreshes", m_open, 0);

        summary();
        $finish;
    end

endmodule